// File: doc/BRIEF.md
# Three-Link Criticality Steering Arbiter

This block sits on the transmit side of one cluster. Each cycle it takes up to `NREQ` transfer requests and places each one on one of three parallel links. The links are a baseline link, a fast narrow link and a slow wide low-power link. Every request carries a class code, a tag and a payload. The class says how urgent and how wide the data is. Address slices that must arrive early, and operands predicted to be narrow, go to the fast link. Operands that were already ready at dispatch, and store data, have their latency hidden, so they go deliberately to the low-power link. Everything else uses the baseline link.

Each link is modelled as a shift pipeline whose length equals its fixed traversal latency. Two latency sets exist: a crossbar set of 2, 1 and 3 cycles, and a ring-hop set of 4, 2 and 6 cycles, for the baseline, fast and low-power links in that order. A mode pin selects the set once, just after reset. At the receiving end each link presents the class, the tag and the payload of the transfer. It also presents a stamp, which is the value of a free-running cycle counter in the cycle the transfer was accepted.

Arbitration is by port priority. When a port finds its preferred link already claimed that cycle, it falls back to the baseline link. When no eligible link is left, the port is held off through its ready signal.

Top module: `xlink_steer`

## Requirements
- R1: While reset is asserted, and in the cycles after it before any request, `out_valid` is all zero.
- R2: The class code selects the preferred link. Link index 0 is the baseline link, 1 is the fast link and 2 is the low-power link. Codes 0 (address slice) and 1 (narrow operand) prefer link 1. Codes 3 (ready-at-dispatch operand) and 4 (store data) prefer link 2. Code 2 (full operand) and the unused codes 5 to 7 prefer link 0.
- R3: With the crossbar latency set, a transfer accepted in cycle c is presented on its link's outputs in cycle c+2 on link 0, c+1 on link 1 and c+3 on link 2. It is presented for exactly one cycle.
- R4: When `ring_mode` is 1 in the first cycle after reset release, the latencies become 4, 2 and 6 cycles for links 0, 1 and 2. The choice of latency set holds until the next reset, whatever `ring_mode` does afterwards.
- R5: Port 0 is always accepted on its preferred link. A higher-numbered port whose preferred link was claimed by a lower-numbered port in the same cycle is sent on link 0, if link 0 is still free.
- R6: `req_ready[p]` is high exactly when port p is valid and was given a link. A port left without an eligible link sees ready low, and its request appears on no link.
- R7: A delivered transfer keeps its class code and tag. Links 0 and 2 keep all `DATA_W` payload bits. Link 1 delivers only the low `FAST_W` payload bits and drives the bits above them as zero.
- R8: `out_sent` holds the value of the cycle counter in the acceptance cycle. The counter is 0 in the first cycle after reset release and rises by one every cycle.
- R9: A link accepts one transfer per cycle. Transfers accepted in consecutive cycles on the same link are delivered in consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| ring_mode | input | 1 | Latency set select, sampled once after reset (1 = ring-hop set) |
| req_valid | input | NREQ | Per-port request valid |
| req_class | input | NREQ*3 | Per-port class code |
| req_tag | input | NREQ*TAG_W | Per-port transfer tag |
| req_data | input | NREQ*DATA_W | Per-port payload |
| req_ready | output | NREQ | Per-port acceptance in the current cycle |
| out_valid | output | 3 | Per-link delivery strobe |
| out_class | output | 9 | Per-link delivered class code |
| out_tag | output | 3*TAG_W | Per-link delivered tag |
| out_data | output | 3*DATA_W | Per-link delivered payload |
| out_sent | output | 3*CYC_W | Per-link acceptance-cycle stamp |

## Verification
The bench builds the block with its defaults: two request ports, a 64-bit payload, an 18-bit fast payload, a 12-bit stamp, and latency sets of 2/1/3 and 4/2/6 cycles. Two ports are the fewest that can create contention. With two ports, the fallback to the baseline link and the stall when the baseline link is also taken can both be reached. The longest pipeline is 6 stages, so every delivery, in both latency sets, falls inside the seven-cycle window that the bench watches after each request. Because of that, an early or late arrival, or a spurious one on another link, is seen as a mismatch.

// File: rtl/xlink_pkg.sv
package xlink_pkg;

  localparam int NLINK    = 3;
  localparam int LNK_BASE = 0;
  localparam int LNK_FAST = 1;
  localparam int LNK_SLOW = 2;
  localparam int CLS_W    = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADDR   = 3'd0,
    CLS_NARROW = 3'd1,
    CLS_FULL   = 3'd2,
    CLS_RDYOP  = 3'd3,
    CLS_STORE  = 3'd4
  } xfer_class_e;

  // Preferred link for a class code
  function automatic logic [1:0] pref_link(input logic [CLS_W-1:0] cls);
    logic [1:0] r;
    case (cls)
      CLS_ADDR, CLS_NARROW: r = 2'(LNK_FAST);
      CLS_RDYOP, CLS_STORE: r = 2'(LNK_SLOW);
      default:              r = 2'(LNK_BASE);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xlink_grant.sv
module xlink_grant
  import xlink_pkg::*;
#(
  parameter int NREQ = 2,
  parameter int PW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREQ-1:0]       req_valid,
  input  logic [NREQ*CLS_W-1:0] req_class,
  output logic [NREQ-1:0]       req_ready,
  output logic [NLINK-1:0]      link_go,
  output logic [NLINK*PW-1:0]   link_src
);

  logic [NLINK-1:0] taken;
  logic [1:0]       want;

  // Ports claim links in index order; preferred link first, then baseline
  always_comb begin
    taken     = '0;
    req_ready = '0;
    link_src  = '0;
    want      = '0;
    for (int p = 0; p < NREQ; p++) begin
      want = pref_link(req_class[p*CLS_W +: CLS_W]);
      if (req_valid[p]) begin
        if (!taken[want]) begin
          taken[want]               = 1'b1;
          link_src[want*PW +: PW]   = PW'(p);
          req_ready[p]              = 1'b1;
        end else if (!taken[LNK_BASE]) begin
          taken[LNK_BASE]             = 1'b1;
          link_src[LNK_BASE*PW +: PW] = PW'(p);
          req_ready[p]                = 1'b1;
        end
      end
    end
  end

  assign link_go = taken;

  // R5: the top-priority port never waits
  a_r5_port0_served: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |-> req_ready[0]);

  // R6: a valid port is refused only when the baseline link is claimed
  for (genvar p = 1; p < NREQ; p++) begin : g_stall_chk
    a_r6_stall_base_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !req_ready[p]) |-> link_go[LNK_BASE]);
  end

endmodule

// File: rtl/xlink_pipe.sv
module xlink_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lat,
  input  logic          in_v,
  input  logic [W-1:0]  in_d,
  output logic          out_v,
  output logic [W-1:0]  out_d
);

  logic [DEPTH-1:0] v_q, v_d, d_en;
  logic [W-1:0]     d_q [DEPTH];
  logic [W-1:0]     d_d [DEPTH];
  logic [LW-1:0]    slot;

  // Entry stage so that the last stage is reached after lat cycles
  assign slot = LW'(DEPTH) - lat;

  always_comb begin
    v_d[0]  = 1'b0;
    d_d[0]  = in_d;
    d_en[0] = 1'b0;
    if (in_v && slot == '0) begin
      v_d[0]  = 1'b1;
      d_en[0] = 1'b1;
    end
    for (int k = 1; k < DEPTH; k++) begin
      v_d[k]  = v_q[k-1];
      d_d[k]  = d_q[k-1];
      d_en[k] = v_q[k-1];
      if (in_v && slot == LW'(k)) begin
        v_d[k]  = 1'b1;
        d_d[k]  = in_d;
        d_en[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (d_en[k]) d_q[k] <= d_d[k];
    end
  end

  assign out_v = v_q[DEPTH-1];
  assign out_d = d_q[DEPTH-1];

  // R3: a single-cycle link presents its transfer on the next cycle
  a_r3_unit_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && lat == LW'(1)) |=> out_v);

endmodule

// File: rtl/xlink_steer.sv
module xlink_steer
  import xlink_pkg::*;
#(
  parameter int NREQ        = 2,
  parameter int TAG_W       = 6,
  parameter int DATA_W      = 64,
  parameter int FAST_W      = 18,
  parameter int CYC_W       = 12,
  parameter int LAT_XB_BASE = 2,
  parameter int LAT_XB_FAST = 1,
  parameter int LAT_XB_SLOW = 3,
  parameter int LAT_RG_BASE = 4,
  parameter int LAT_RG_FAST = 2,
  parameter int LAT_RG_SLOW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ring_mode,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [NREQ*CLS_W-1:0]    req_class,
  input  logic [NREQ*TAG_W-1:0]    req_tag,
  input  logic [NREQ*DATA_W-1:0]   req_data,
  output logic [NREQ-1:0]          req_ready,
  output logic [NLINK-1:0]         out_valid,
  output logic [NLINK*CLS_W-1:0]   out_class,
  output logic [NLINK*TAG_W-1:0]   out_tag,
  output logic [NLINK*DATA_W-1:0]  out_data,
  output logic [NLINK*CYC_W-1:0]   out_sent
);

  localparam int PW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int XW = CLS_W + TAG_W + DATA_W + CYC_W;

  // Latency-set capture and cycle counter
  logic             lock_q, ring_q, ring_d, cfg_en, ring_use;
  logic [CYC_W-1:0] cyc_q, cyc_d;

  assign cfg_en = !lock_q;
  assign ring_d = ring_mode;
  assign cyc_d  = cyc_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      ring_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      cyc_q <= cyc_d;
      if (cfg_en) begin
        ring_q <= ring_d;
        lock_q <= 1'b1;
      end
    end
  end

  assign ring_use = lock_q ? ring_q : ring_mode;

  // R4: once captured, the latency set does not move
  a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(ring_q));

  logic [NLINK-1:0]    link_go;
  logic [NLINK*PW-1:0] link_src;

  xlink_grant #(.NREQ(NREQ), .PW(PW)) u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_class (req_class),
    .req_ready (req_ready),
    .link_go   (link_go),
    .link_src  (link_src)
  );

  for (genvar l = 0; l < NLINK; l++) begin : g_link
    localparam int LXB = (l == LNK_BASE) ? LAT_XB_BASE :
                         (l == LNK_FAST) ? LAT_XB_FAST : LAT_XB_SLOW;
    localparam int LRG = (l == LNK_BASE) ? LAT_RG_BASE :
                         (l == LNK_FAST) ? LAT_RG_FAST : LAT_RG_SLOW;
    localparam int DEP = (LXB > LRG) ? LXB : LRG;
    localparam int LW  = $clog2(DEP + 1);

    logic [PW-1:0]     src;
    logic [CLS_W-1:0]  cls;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] dat;
    logic [LW-1:0]     lat;
    logic [XW-1:0]     in_w, out_w;
    logic              ov;

    assign src = link_src[l*PW +: PW];
    assign cls = req_class[src*CLS_W +: CLS_W];
    assign tag = req_tag[src*TAG_W +: TAG_W];
    assign lat = ring_use ? LW'(LRG) : LW'(LXB);

    if (l == LNK_FAST) begin : g_narrow
      assign dat = {{(DATA_W-FAST_W){1'b0}}, req_data[src*DATA_W +: FAST_W]};
      // R7: nothing above the narrow field leaves the fast link
      a_r7_fast_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ov |-> (out_w[CYC_W+FAST_W +: DATA_W-FAST_W] == '0));
    end else begin : g_wide
      assign dat = req_data[src*DATA_W +: DATA_W];
    end

    assign in_w = {cls, tag, dat, cyc_q};

    xlink_pipe #(.W(XW), .DEPTH(DEP), .LW(LW)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .lat   (lat),
      .in_v  (link_go[l]),
      .in_d  (in_w),
      .out_v (ov),
      .out_d (out_w)
    );

    assign out_valid[l]                 = ov;
    assign out_class[l*CLS_W +: CLS_W]  = out_w[XW-1 -: CLS_W];
    assign out_tag[l*TAG_W +: TAG_W]    = out_w[XW-CLS_W-1 -: TAG_W];
    assign out_data[l*DATA_W +: DATA_W] = out_w[CYC_W +: DATA_W];
    assign out_sent[l*CYC_W +: CYC_W]   = out_w[0 +: CYC_W];
  end

endmodule

// File: tb/sim_xlink_steer.sv
module sim_xlink_steer;
  import xlink_pkg::*;

  localparam int NREQ = 2, TAG_W = 6, DATA_W = 64, FAST_W = 18, CYC_W = 12;
  localparam logic [63:0] FMASK = (64'd1 << FAST_W) - 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_mode = 1'b0;
  logic [NREQ-1:0]        req_valid = '0;
  logic [NREQ*3-1:0]      req_class = '0;
  logic [NREQ*TAG_W-1:0]  req_tag = '0;
  logic [NREQ*DATA_W-1:0] req_data = '0;
  logic [NREQ-1:0]        req_ready;
  logic [2:0]             out_valid;
  logic [8:0]             out_class;
  logic [3*TAG_W-1:0]     out_tag;
  logic [3*DATA_W-1:0]    out_data;
  logic [3*CYC_W-1:0]     out_sent;

  int checks = 0;
  int errors = 0;
  logic [CYC_W-1:0] bcnt;

  always #4 clk = ~clk;

  // Independent model of the acceptance-cycle counter (R8)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= bcnt + 1'b1;

  xlink_steer u0 (
    .clk(clk), .rst_n(rst_n), .ring_mode(ring_mode),
    .req_valid(req_valid), .req_class(req_class), .req_tag(req_tag),
    .req_data(req_data), .req_ready(req_ready), .out_valid(out_valid),
    .out_class(out_class), .out_tag(out_tag), .out_data(out_data),
    .out_sent(out_sent)
  );

  function automatic int lat_of(input int l, input bit ring);
    case (l)
      0:       return ring ? 4 : 2;
      1:       return ring ? 2 : 1;
      default: return ring ? 6 : 3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit ring);
    req_valid = '0;
    ring_mode = ring;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  // R1: nothing delivered out of reset
  task automatic t_reset;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid == 3'b000, "R1", "idle out_valid", 64'(out_valid), 64'd0);
    end
  endtask

  // One request cycle on up to two ports, then a seven-cycle watch of all links.
  // e0/e1: expected link index, 3 means stalled.
  task automatic run_pair(input string rq, input bit ring,
      input bit v0, input logic [2:0] c0, input logic [5:0] t0, input logic [63:0] d0, input int e0,
      input bit v1, input logic [2:0] c1, input logic [5:0] t1, input logic [63:0] d1, input int e1);
    logic [CYC_W-1:0] s0;
    @(negedge clk);
    req_valid = {v1, v0};
    req_class = {c1, c0};
    req_tag   = {t1, t0};
    req_data  = {d1, d0};
    s0 = bcnt;
    #1;
    chk(req_ready[0] == v0, rq, "port0 ready", 64'(req_ready[0]), 64'(v0));
    chk(req_ready[1] == (v1 && e1 != 3), rq, "port1 ready", 64'(req_ready[1]),
        64'(v1 && e1 != 3));
    @(negedge clk);
    req_valid = '0;
    for (int k = 1; k <= 7; k++) begin
      for (int l = 0; l < 3; l++) begin
        bit ev;
        logic [2:0]  ec;
        logic [5:0]  et;
        logic [63:0] ed;
        ev = 1'b0; ec = '0; et = '0; ed = '0;
        if (v0 && e0 == l && lat_of(l, ring) == k) begin ev = 1'b1; ec = c0; et = t0; ed = d0; end
        if (v1 && e1 == l && lat_of(l, ring) == k) begin ev = 1'b1; ec = c1; et = t1; ed = d1; end
        if (l == 1) ed = ed & FMASK;
        chk(out_valid[l] == ev, rq, $sformatf("link%0d valid at +%0d", l, k),
            64'(out_valid[l]), 64'(ev));
        if (ev) begin
          chk(out_class[l*3 +: 3] == ec, rq, "class", 64'(out_class[l*3 +: 3]), 64'(ec));
          chk(out_tag[l*TAG_W +: TAG_W] == et, rq, "tag", 64'(out_tag[l*TAG_W +: TAG_W]), 64'(et));
          chk(out_data[l*DATA_W +: DATA_W] == ed, rq, "data", out_data[l*DATA_W +: DATA_W], ed);
          chk(out_sent[l*CYC_W +: CYC_W] == s0, rq, "R8 stamp",
              64'(out_sent[l*CYC_W +: CYC_W]), 64'(s0));
        end
      end
      if (k < 7) @(negedge clk);
    end
  endtask

  // R2, R3, R8: every class code on port 0 alone
  task automatic t_classes(input bit ring, input string rq);
    int exp_link [8] = '{1, 1, 0, 2, 2, 0, 0, 0};
    for (int c = 0; c < 8; c++)
      run_pair(rq, ring, 1'b1, 3'(c), 6'(c + 8), 64'h0123_4567_89AB_CDEF ^ 64'(c), exp_link[c],
               1'b0, 3'd0, 6'd0, 64'd0, 3);
  endtask

  // R7: wide payload on the fast link is cut to the narrow field
  task automatic t_narrow;
    run_pair("R7", 1'b0, 1'b1, CLS_NARROW, 6'h2A, 64'hDEAD_BEEF_CAFE_1234, 1,
             1'b0, 3'd0, 6'd0, 64'd0, 3);
    run_pair("R7", 1'b0, 1'b1, CLS_FULL, 6'h15, 64'hFFFF_FFFF_FFFF_FFFF, 0,
             1'b0, 3'd0, 6'd0, 64'd0, 3);
  endtask

  // R5: contention for fast and slow links pushes port 1 to the baseline link
  task automatic t_fallback;
    run_pair("R5", 1'b0, 1'b1, CLS_NARROW, 6'h01, 64'h11, 1,
             1'b1, CLS_ADDR, 6'h02, 64'hAAAA_0000_0000_0022, 0);
    run_pair("R5", 1'b0, 1'b1, CLS_STORE, 6'h03, 64'h33, 2,
             1'b1, CLS_RDYOP, 6'h04, 64'h44, 0);
    run_pair("R5", 1'b0, 1'b1, CLS_FULL, 6'h05, 64'h55, 0,
             1'b1, CLS_NARROW, 6'h06, 64'h66, 1);
  endtask

  // R6: port 1 refused when the baseline link is already claimed
  task automatic t_stall;
    run_pair("R6", 1'b0, 1'b1, CLS_FULL, 6'h07, 64'h77, 0,
             1'b1, CLS_FULL, 6'h08, 64'h88, 3);
    run_pair("R6", 1'b0, 1'b1, 3'd6, 6'h09, 64'h99, 0,
             1'b1, 3'd7, 6'h0A, 64'hAA, 3);
  endtask

  // R9: three back-to-back transfers on the low-power link
  task automatic t_burst;
    logic [CYC_W-1:0] s0;
    @(negedge clk);
    s0 = bcnt;
    for (int j = 0; j < 3; j++) begin
      if (j > 0) @(negedge clk);
      req_valid = 2'b01;
      req_class = {3'd0, CLS_STORE};
      req_tag   = {6'd0, 6'(j + 20)};
      req_data  = {64'd0, 64'(j + 100)};
    end
    @(negedge clk);
    req_valid = '0;
    for (int j = 0; j < 4; j++) begin
      if (j > 0) @(negedge clk);
      chk(out_valid[2] == (j < 3), "R9", $sformatf("burst valid %0d", j),
          64'(out_valid[2]), 64'(j < 3));
      if (j < 3) begin
        chk(out_tag[2*TAG_W +: TAG_W] == 6'(j + 20), "R9", "burst order",
            64'(out_tag[2*TAG_W +: TAG_W]), 64'(j + 20));
        chk(out_sent[2*CYC_W +: CYC_W] == s0 + CYC_W'(j), "R9", "burst stamp",
            64'(out_sent[2*CYC_W +: CYC_W]), 64'(s0 + CYC_W'(j)));
      end
    end
  endtask

  // R4: ring set captured at reset; later toggling of ring_mode ignored
  task automatic t_ring;
    repeat (2) @(negedge clk);
    ring_mode = 1'b0;
    t_classes(1'b1, "R4");
    run_pair("R4", 1'b1, 1'b1, CLS_ADDR, 6'h31, 64'h1234, 1,
             1'b1, CLS_NARROW, 6'h32, 64'h5678, 0);
  endtask

  task automatic t_xbar_hold;
    repeat (2) @(negedge clk);
    ring_mode = 1'b1;
    run_pair("R4", 1'b0, 1'b1, CLS_STORE, 6'h3C, 64'hC0FFEE, 2,
             1'b1, CLS_ADDR, 6'h3D, 64'hBEEF, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_reset();
    t_classes(1'b0, "R2 R3");
    t_narrow();
    t_fallback();
    t_stall();
    t_burst();
    t_xbar_hold();
    do_reset(1'b1);
    t_reset();
    t_ring();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule